// File: doc/BRIEF.md
# Low-Power Mode Clock Controller

The block holds four power-mode control bits and turns them into enable signals for the core clock, a fast subsystem clock, a slow auxiliary clock, a fast oscillator and a crystal oscillator. Each oscillator keeps running whenever a running clock still selects it as its source, even if its stop bit is set. This lets software pick a power level with one register write.

The block also handles interrupt entry and exit in hardware. When a request is taken, the current bits are copied into a one-deep save register, which stands in for the stacked status word. The bits that stop the core, the subsystem clock and the crystal are then cleared, so the handler gets a clock. The fast-oscillator stop bit is kept. While the handler runs it may rewrite the saved copy. On return, the saved copy, edited or not, becomes the live mode. In the deepest state, where both oscillators are stopped, only the non-maskable request can wake the block.

Top module: `lpm_clk_ctrl`

## Requirements
- R1: After reset all four mode bits are 0, the save register is 0, the block is not in a handler, irq_ack_o is 0, and the core and subsystem clock enables are 1.
- R2: With wr_en_i high and no request taken, mode_o takes wr_bits_i on the next cycle. Bit 0 is core halt, bit 1 is subsystem clock off, bit 2 is fast oscillator off and bit 3 is crystal off.
- R3: mclk_en_o is the inverse of bit 0, and smclk_en_o is the inverse of bit 1.
- R4: fosc_en_o is 0 only when bit 2 is set and no enabled core or subsystem clock selects source code 0.
- R5: xosc_en_o is 0 only when bit 3 is set and no enabled core or subsystem clock selects source code 1. aclk_en_o equals xosc_en_o when aclk_xtal_i is 1, and is 1 otherwise.
- R6: A taken request sets in_handler_o and pulses irq_ack_o for exactly one cycle on the next cycle. In that same cycle it loads saved_o with the prior bits and clears bits 0, 1 and 3 of mode_o, while bit 2 keeps its prior value.
- R7: If a request is taken in the cycle of a mode write, the request wins. saved_o holds the written value, and bit 2 of mode_o follows the written value.
- R8: Inside a handler, save_wr_en_i loads save_wr_bits_i into saved_o. Outside a handler it has no effect.
- R9: A return strobe inside a handler copies the saved copy (including an edit made in the same cycle) into mode_o and leaves the handler. A return outside a handler is ignored. A return takes priority over a same-cycle mode write.
- R10: When both oscillator enables are 0, irq_i is not taken, but nmi_i is.
- R11: No request is taken while in a handler. irq_ack_o stays 0 until after the return.
- R12: A mode write inside a handler changes mode_o and leaves saved_o unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Mode bit write strobe |
| wr_bits_i | input | 4 | Mode bits to write |
| save_wr_en_i | input | 1 | Write strobe for the saved copy |
| save_wr_bits_i | input | 4 | New value for the saved copy |
| irq_i | input | 1 | Maskable request |
| nmi_i | input | 1 | Non-maskable request |
| ret_i | input | 1 | Return-from-handler strobe |
| mclk_src_i | input | SRC_W | Core clock source code |
| smclk_src_i | input | SRC_W | Subsystem clock source code |
| aclk_xtal_i | input | 1 | Auxiliary clock taken from the crystal |
| irq_ack_o | output | 1 | Request accepted pulse |
| in_handler_o | output | 1 | Handler in progress |
| mode_o | output | 4 | Live mode bits |
| saved_o | output | 4 | Saved copy of the mode bits |
| mclk_en_o | output | 1 | Core clock enable |
| smclk_en_o | output | 1 | Subsystem clock enable |
| aclk_en_o | output | 1 | Auxiliary clock enable |
| fosc_en_o | output | 1 | Fast oscillator enable |
| xosc_en_o | output | 1 | Crystal oscillator enable |

## Verification
A wrong live mode register shows at the clock enables in the cycle after the bad update. The enables are combinational from that register and the source selects, so there is no further delay. A corrupted save register stays hidden at the enables until the next return, but saved_o exposes it at once, so the bench compares it on every cycle. A wrong handler flag shows either as a missing or duplicated acknowledge pulse, or as a return that does nothing. Both appear one cycle after the offending request or return strobe.

// File: rtl/lpm_clk_pkg.sv
package lpm_clk_pkg;
  localparam int MODE_W  = 4;
  localparam int NUM_OSC = 2;
  // mode bit positions, decoded by software
  localparam int B_CPU  = 0;
  localparam int B_SUB  = 1;
  localparam int B_FOSC = 2;
  localparam int B_XOSC = 3;

  typedef logic [MODE_W-1:0] mode_t;

  // bits forced clear on handler entry; fast osc stop bit survives
  localparam mode_t ENTRY_CLR = mode_t'((1 << B_CPU) | (1 << B_SUB) | (1 << B_XOSC));

  function automatic int osc_off_bit(int idx);
    return (idx == 0) ? B_FOSC : B_XOSC;
  endfunction
endpackage

// File: rtl/lpm_clk_gate.sv
module lpm_clk_gate
  import lpm_clk_pkg::*;
#(
  parameter int SRC_W     = 2,
  parameter int FOSC_CODE = 0,
  parameter int XOSC_CODE = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  mode_t            mode_i,
  input  logic [SRC_W-1:0] mclk_src_i,
  input  logic [SRC_W-1:0] smclk_src_i,
  input  logic             aclk_xtal_i,
  output logic             mclk_en_o,
  output logic             smclk_en_o,
  output logic [NUM_OSC-1:0] osc_en_o,
  output logic             aclk_en_o
);
  assign mclk_en_o  = !mode_i[B_CPU];
  assign smclk_en_o = !mode_i[B_SUB];

  for (genvar g = 0; g < NUM_OSC; g++) begin : g_osc
    localparam logic [SRC_W-1:0] CODE  = (g == 0) ? SRC_W'(FOSC_CODE) : SRC_W'(XOSC_CODE);
    localparam int               OFF_B = osc_off_bit(g);
    logic used_by_m, used_by_s;
    assign used_by_m   = mclk_en_o  && (mclk_src_i  == CODE);
    assign used_by_s   = smclk_en_o && (smclk_src_i == CODE);
    assign osc_en_o[g] = !mode_i[OFF_B] || used_by_m || used_by_s;
  end

  assign aclk_en_o = aclk_xtal_i ? osc_en_o[1] : 1'b1;

  assert_fosc_demand_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mode_i[B_CPU] && mclk_src_i == SRC_W'(FOSC_CODE)) |-> osc_en_o[0]);
  assert_xosc_demand_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!mode_i[B_SUB] && smclk_src_i == SRC_W'(XOSC_CODE)) |-> osc_en_o[1]);
  assert_aclk_follow_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    aclk_xtal_i |-> (aclk_en_o == osc_en_o[1]));
endmodule

// File: rtl/lpm_wake_arb.sv
module lpm_wake_arb
  import lpm_clk_pkg::*;
(
  input  logic               irq_i,
  input  logic               nmi_i,
  input  logic               in_handler_i,
  input  logic [NUM_OSC-1:0] osc_en_i,
  output logic               take_o
);
  logic deep;
  // no running oscillator: maskable sources have no clock to raise requests
  assign deep   = ~|osc_en_i;
  assign take_o = !in_handler_i && (nmi_i || (irq_i && !deep));
endmodule

// File: rtl/lpm_mode_ctx.sv
module lpm_mode_ctx
  import lpm_clk_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  take_i,
  input  logic  wr_en_i,
  input  mode_t wr_bits_i,
  input  logic  save_wr_en_i,
  input  mode_t save_wr_bits_i,
  input  logic  ret_i,
  output mode_t mode_o,
  output mode_t saved_o,
  output logic  in_handler_o,
  output logic  ack_o
);
  mode_t mode_q, saved_q, cur_bits, ret_bits;
  logic  inh_q, ack_q;

  // a same-cycle write is what gets stacked
  assign cur_bits = wr_en_i ? wr_bits_i : mode_q;
  assign ret_bits = save_wr_en_i ? save_wr_bits_i : saved_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q  <= '0;
      saved_q <= '0;
      inh_q   <= 1'b0;
      ack_q   <= 1'b0;
    end else if (take_i) begin
      saved_q <= cur_bits;
      mode_q  <= cur_bits & ~ENTRY_CLR;
      inh_q   <= 1'b1;
      ack_q   <= 1'b1;
    end else begin
      ack_q <= 1'b0;
      if (inh_q && ret_i) begin
        mode_q <= ret_bits;
        inh_q  <= 1'b0;
      end else if (wr_en_i) begin
        mode_q <= wr_bits_i;
      end
      if (inh_q && save_wr_en_i) saved_q <= save_wr_bits_i;
    end
  end

  assign mode_o       = mode_q;
  assign saved_o      = saved_q;
  assign in_handler_o = inh_q;
  assign ack_o        = ack_q;

  assert_entry_wake_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_i |=> (!mode_q[B_CPU] && !mode_q[B_SUB] && !mode_q[B_XOSC] && inh_q && ack_q));
  assert_fosc_kept_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    take_i |=> (mode_q[B_FOSC] == saved_q[B_FOSC]));
  assert_ack_pulse_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_q |=> !ack_q);
  assert_ret_restore_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inh_q && ret_i && !save_wr_en_i) |=> (mode_q == $past(saved_q) && !inh_q));
  assert_saved_frozen_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!save_wr_en_i && !take_i) |=> $stable(saved_q));
endmodule

// File: rtl/lpm_clk_ctrl.sv
module lpm_clk_ctrl
  import lpm_clk_pkg::*;
#(
  parameter int SRC_W     = 2,
  parameter int FOSC_CODE = 0,
  parameter int XOSC_CODE = 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [3:0]       wr_bits_i,
  input  logic             save_wr_en_i,
  input  logic [3:0]       save_wr_bits_i,
  input  logic             irq_i,
  input  logic             nmi_i,
  input  logic             ret_i,
  input  logic [SRC_W-1:0] mclk_src_i,
  input  logic [SRC_W-1:0] smclk_src_i,
  input  logic             aclk_xtal_i,
  output logic             irq_ack_o,
  output logic             in_handler_o,
  output logic [3:0]       mode_o,
  output logic [3:0]       saved_o,
  output logic             mclk_en_o,
  output logic             smclk_en_o,
  output logic             aclk_en_o,
  output logic             fosc_en_o,
  output logic             xosc_en_o
);
  mode_t              mode, saved;
  logic               take, inh, ack;
  logic [NUM_OSC-1:0] osc_en;

  lpm_mode_ctx u_ctx (
    .clk_i, .rst_ni,
    .take_i        (take),
    .wr_en_i,
    .wr_bits_i     (mode_t'(wr_bits_i)),
    .save_wr_en_i,
    .save_wr_bits_i(mode_t'(save_wr_bits_i)),
    .ret_i,
    .mode_o        (mode),
    .saved_o       (saved),
    .in_handler_o  (inh),
    .ack_o         (ack)
  );

  lpm_wake_arb u_arb (
    .irq_i, .nmi_i,
    .in_handler_i(inh),
    .osc_en_i    (osc_en),
    .take_o      (take)
  );

  lpm_clk_gate #(.SRC_W(SRC_W), .FOSC_CODE(FOSC_CODE), .XOSC_CODE(XOSC_CODE)) u_gate (
    .clk_i, .rst_ni,
    .mode_i    (mode),
    .mclk_src_i, .smclk_src_i, .aclk_xtal_i,
    .mclk_en_o, .smclk_en_o,
    .osc_en_o  (osc_en),
    .aclk_en_o
  );

  assign mode_o       = mode;
  assign saved_o      = saved;
  assign in_handler_o = inh;
  assign irq_ack_o    = ack;
  assign fosc_en_o    = osc_en[0];
  assign xosc_en_o    = osc_en[1];

  assert_deep_ignore_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!inh && !fosc_en_o && !xosc_en_o && irq_i && !nmi_i) |=> !irq_ack_o);
  assert_no_nest_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inh && !ret_i) |=> !irq_ack_o);
endmodule

// File: tb/lpm_clk_ctrl_tb_top.sv
module lpm_clk_ctrl_tb_top;
  logic clk = 0, rst_n = 0;
  always #4 clk = ~clk;

  logic       wr_en = 0, sv_en = 0, irq = 0, nmi = 0, ret = 0, ax = 1;
  logic [3:0] wr_bits = 0, sv_bits = 0;
  logic [1:0] msrc = 0, ssrc = 0;
  logic       ack, inh, mclk_en, smclk_en, aclk_en, fosc_en, xosc_en;
  logic [3:0] mode, saved;

  lpm_clk_ctrl dut_i (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_bits_i(wr_bits),
    .save_wr_en_i(sv_en), .save_wr_bits_i(sv_bits), .irq_i(irq), .nmi_i(nmi),
    .ret_i(ret), .mclk_src_i(msrc), .smclk_src_i(ssrc), .aclk_xtal_i(ax),
    .irq_ack_o(ack), .in_handler_o(inh), .mode_o(mode), .saved_o(saved),
    .mclk_en_o(mclk_en), .smclk_en_o(smclk_en), .aclk_en_o(aclk_en),
    .fosc_en_o(fosc_en), .xosc_en_o(xosc_en));

  int checks = 0, failures = 0;
  logic [3:0] m_mode = 0, m_saved = 0;
  logic       m_inh = 0, m_ack = 0;

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic m_fosc();
    return !m_mode[2] || (!m_mode[0] && msrc == 0) || (!m_mode[1] && ssrc == 0);
  endfunction
  function automatic logic m_xosc();
    return !m_mode[3] || (!m_mode[0] && msrc == 1) || (!m_mode[1] && ssrc == 1);
  endfunction

  task automatic compare();
    check("R2 mode", mode, m_mode);
    check("R8 saved", saved, m_saved);
    check("R6 in_handler", inh, m_inh);
    check("R6 ack", ack, m_ack);
    check("R3 mclk", mclk_en, !m_mode[0]);
    check("R3 smclk", smclk_en, !m_mode[1]);
    check("R4 fosc", fosc_en, m_fosc());
    check("R5 xosc", xosc_en, m_xosc());
    check("R5 aclk", aclk_en, ax ? m_xosc() : 1'b1);
  endtask

  // model advance from inputs held since the last falling edge, then compare
  task automatic tick();
    logic [3:0] cur;
    logic take;
    take = !m_inh && (nmi || (irq && (m_fosc() || m_xosc())));
    cur  = wr_en ? wr_bits : m_mode;
    if (take) begin
      m_saved = cur; m_mode = cur & 4'b0100; m_inh = 1; m_ack = 1;
    end else begin
      m_ack = 0;
      if (m_inh && ret) begin
        m_mode = sv_en ? sv_bits : m_saved; m_inh = 0;
      end else if (wr_en) m_mode = wr_bits;
      if (m_inh && sv_en && !ret) m_saved = sv_bits;
      else if (inh && sv_en && ret) m_saved = sv_bits;
    end
    @(negedge clk);
    compare();
    wr_en = 0; sv_en = 0; irq = 0; nmi = 0; ret = 0;
  endtask

  task automatic write_mode(logic [3:0] b);
    wr_en = 1; wr_bits = b; tick();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check("R1 mode", mode, 0); check("R1 saved", saved, 0);
    check("R1 inh", inh, 0);   check("R1 ack", ack, 0);
    check("R1 mclk", mclk_en, 1); check("R1 smclk", smclk_en, 1);
    compare();

    // R2/R3/R4: core halt, fast osc kept for subsystem clock
    write_mode(4'b0101);
    check("R4 fosc held by smclk", fosc_en, 1);

    // R6 entry from halt
    irq = 1; tick();
    check("R6 saved prior", saved, 4'b0101);
    check("R6 fosc bit kept", mode, 4'b0100);
    tick();
    check("R6 ack one cycle", ack, 0);
    // R11: requests in handler not taken
    irq = 1; nmi = 1; tick();
    check("R11 no ack in handler", ack, 0);
    // R12: write in handler leaves saved
    write_mode(4'b0010);
    check("R12 saved untouched", saved, 4'b0101);
    // R8: edit saved to deepest state, then return
    sv_en = 1; sv_bits = 4'b1111; tick();
    check("R8 edited", saved, 4'b1111);
    ret = 1; tick();
    check("R9 edited mode restored", mode, 4'b1111);
    check("R9 left handler", inh, 0);
    check("R10 both osc off", fosc_en | xosc_en, 0);

    // R10: maskable ignored in deepest state, non-maskable wakes
    repeat (3) begin irq = 1; tick(); check("R10 irq ignored", inh, 0); end
    nmi = 1; tick();
    check("R10 nmi wakes", mode, 4'b0100);
    // R9: return with same-cycle write, return wins
    ret = 1; wr_en = 1; wr_bits = 4'b0001; tick();
    check("R9 ret over write", mode, 4'b1111);

    // R9/R8 outside handler: ignored
    write_mode(4'b0000);
    ret = 1; tick();
    check("R9 ret ignored", mode, 0);
    sv_en = 1; sv_bits = 4'b0011; tick();
    check("R8 edit ignored", saved, 4'b1111);

    // R7: write and request in the same cycle
    wr_en = 1; wr_bits = 4'b0110; irq = 1; tick();
    check("R7 saved written value", saved, 4'b0110);
    check("R7 fosc bit from write", mode, 4'b0100);
    // edit and return in the same cycle
    ret = 1; sv_en = 1; sv_bits = 4'b1001; tick();
    check("R9 same-cycle edit", mode, 4'b1001);

    // R3/R4/R5 sweep over modes and source selects
    for (int s = 0; s < 4; s++) begin
      for (int m = 0; m < 16; m++) begin
        msrc = 2'(s); ssrc = 2'((s + m) % 4); ax = m[0] ^ s[1];
        write_mode(4'(m));
      end
    end
    // entry/return cycles under varied sources
    for (int m = 0; m < 16; m++) begin
      msrc = 2'(m % 3); ssrc = 2'(1 - (m % 2)); ax = 1;
      write_mode(4'(m));
      irq = 1; tick();
      nmi = 1; tick();
      ret = 1; tick();
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule